// File: doc/BRIEF.md
# Independent Watchdog Counter with Prescaler

This block is a watchdog that, once started, cannot be stopped. Its counting logic runs on a slow oscillator clock. A bus-clock write port gives software four actions, all through 16-bit keys and two configuration fields: start the watchdog, open the configuration fields for writing, set the divide code and the reload value, and feed (service) the counter. A prescaler divides the slow clock by four times a power of two. Its tick decrements a down-counter of the reload width. When that counter runs out, a one-slow-cycle reset request goes to the chip's reset generator, and counting starts again from the reload value.

A configuration write does not act at once. Each field is held in a bus-side shadow and handed to the slow domain through a toggle handshake that uses two-flop synchronisers in both directions. A busy flag for each field stays high until the new value has been taken up and acknowledged. Software polls these flags before it relies on the new timing. Starting the watchdog also raises a request that keeps the slow oscillator running. Both that request and the running state hold until the next reset.

Top module: `iwdt_top`

## Requirements
- R1: The prescaler divides the slow clock by 4 << code. The code is bits [CODE_W-1:0] of a write to address 1, where CODE_W is 3, or 4 when WIDE_DIV=1. Codes above the largest supported code (6, giving divide 256, or 8 with WIDE_DIV=1, giving divide 1024) act as the largest code. The code resets to 0.
- R2: While running, reset_req pulses every (4 << code) × (reload + 1) slow cycles. The reload value is bits [RLD_W-1:0] of a write to address 2, is 12 bits by default and resets to 0xFFF.
- R3: Writing key 0xCCCC to address 0 sets wdg_active and osc_force_on on the next bus edge. No later write of any kind clears either of them before reset.
- R4: reset_req stays low until the start key has crossed into the slow domain. On start, the counter begins from the reload value.
- R5: Writes to addresses 1 and 2 are accepted only after key 0x5555. Any other value written to address 0 (0xAAAA and 0xCCCC included) locks them again. A locked write leaves the busy flags at 0 and changes no timing.
- R6: An accepted field write raises that field's busy flag (pre_busy for address 1, rld_busy for address 2) on the next bus edge. The flag drops only after the value has reached the slow domain and the acknowledge has come back through two synchroniser flops. Writes to a field while its flag is high are ignored.
- R7: Key 0xAAAA reloads the counter from the reload value and clears the prescaler. Feeds spaced closer than the timeout keep reset_req low.
- R8: When a feed arrives in the same slow cycle in which the counter would expire, the feed wins and no reset_req is raised.
- R9: reset_req is high for exactly one slow cycle, and the next period is a full timeout from the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus | input | 1 | Synchronous active-high reset, bus domain |
| clk_slow | input | 1 | Slow oscillator clock |
| rst_slow | input | 1 | Synchronous active-high reset, slow domain |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | 0 key, 1 divide code, 2 reload, 3 unused |
| bus_wdata | input | 16 | Write data |
| pre_busy | output | 1 | Divide code update in flight |
| rld_busy | output | 1 | Reload update in flight |
| wdg_active | output | 1 | Watchdog started (sticky) |
| osc_force_on | output | 1 | Keep-oscillator-running request (sticky) |
| reset_req | output | 1 | One-slow-cycle reset request |

## Verification
A feed and an expiry can land in the same slow cycle, and R8 decides which one takes effect. The bench sets a 40-cycle timeout. After each reset request it issues a feed, and across successive periods it moves that feed one bus cycle at a time through the expiry instant, so that the crossed feed arrives just before, exactly on, and just after the zero tick. The bench judges the result by requiring that no two requests are ever closer than a full period and that every request is a single cycle wide. A bound property also checks that a feed seen together with the zero tick is never followed by a request.

// File: rtl/iwdt_pkg.sv
`timescale 1ns/1ps
package iwdt_pkg;
  localparam logic [15:0] KEY_START = 16'hCCCC;
  localparam logic [15:0] KEY_OPEN  = 16'h5555;
  localparam logic [15:0] KEY_FEED  = 16'hAAAA;

  localparam logic [1:0] ADDR_KEY = 2'd0;
  localparam logic [1:0] ADDR_DIV = 2'd1;
  localparam logic [1:0] ADDR_RLD = 2'd2;
endpackage

// File: rtl/iwdt_sync.sv
`timescale 1ns/1ps
module iwdt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/iwdt_keys.sv
`timescale 1ns/1ps
module iwdt_keys
  import iwdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  input  logic        pre_busy,
  input  logic        rld_busy,
  output logic        pre_ld,
  output logic        rld_ld,
  output logic        active,
  output logic        osc_on,
  output logic        feed_tgl
);
  logic unlocked;
  logic key_wr;

  assign key_wr = we && (addr == ADDR_KEY);
  // field loads need an open lock and an idle handshake for that field
  assign pre_ld = we && (addr == ADDR_DIV) && unlocked && !pre_busy;
  assign rld_ld = we && (addr == ADDR_RLD) && unlocked && !rld_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      active   <= 1'b0;
      osc_on   <= 1'b0;
      feed_tgl <= 1'b0;
    end else if (key_wr) begin
      unlocked <= (wdata == KEY_OPEN);
      if (wdata == KEY_START) begin
        active <= 1'b1;
        osc_on <= 1'b1;
      end
      if (wdata == KEY_FEED) feed_tgl <= ~feed_tgl;
    end
  end
endmodule

// File: rtl/iwdt_xfer.sv
`timescale 1ns/1ps
module iwdt_xfer #(
  parameter int           W       = 12,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int           STAGES  = 2
) (
  input  logic         clk_a,
  input  logic         rst_a,
  input  logic         load_a,
  input  logic [W-1:0] din_a,
  output logic         busy_a,
  input  logic         clk_b,
  input  logic         rst_b,
  output logic [W-1:0] dout_b
);
  logic [W-1:0] shadow;
  logic         req;
  logic         ack_a;
  logic         req_b;
  logic         seen;

  // source side: shadow stays stable while busy, so it is safe to sample in b
  always_ff @(posedge clk_a) begin
    if (rst_a) begin
      shadow <= RST_VAL;
      req    <= 1'b0;
      busy_a <= 1'b0;
    end else if (load_a) begin
      shadow <= din_a;
      req    <= ~req;
      busy_a <= 1'b1;
    end else if (ack_a == req) begin
      busy_a <= 1'b0;
    end
  end

  iwdt_sync #(.W(1), .STAGES(STAGES)) u_req_sync (
    .clk(clk_b), .rst(rst_b), .d(req), .q(req_b)
  );

  // destination side: take the shadow when a new toggle is seen, echo it back
  always_ff @(posedge clk_b) begin
    if (rst_b) begin
      seen   <= 1'b0;
      dout_b <= RST_VAL;
    end else if (req_b != seen) begin
      seen   <= req_b;
      dout_b <= shadow;
    end
  end

  iwdt_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk(clk_a), .rst(rst_a), .d(seen), .q(ack_a)
  );
endmodule

// File: rtl/iwdt_count.sv
`timescale 1ns/1ps
module iwdt_count #(
  parameter int RLD_W    = 12,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 6,
  parameter int DIVW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_s,
  input  logic              feed_s,
  input  logic [CODE_W-1:0] code,
  input  logic [RLD_W-1:0]  reload,
  output logic              feed_hit,
  output logic              zero_tick,
  output logic              expire
);
  localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(MAX_CODE);

  logic              live;
  logic              run_d;
  logic              feed_d;
  logic [DIVW-1:0]   pcnt;
  logic [DIVW-1:0]   plast;
  logic [CODE_W-1:0] code_eff;
  logic [CODE_W-1:0] shamt;
  logic [RLD_W-1:0]  cnt;
  logic              tick;
  logic              start;

  // divide is 4 << code; all-ones of DIVW bits is the top divide minus one
  always_comb begin
    code_eff = (code > CODE_TOP) ? CODE_TOP : code;
    shamt    = CODE_TOP - code_eff;
    plast    = {DIVW{1'b1}} >> shamt;
  end

  assign start     = run_s && !run_d;
  assign tick      = live && (pcnt >= plast);
  assign feed_hit  = live && (feed_s != feed_d);
  assign zero_tick = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= 1'b0;
      run_d  <= 1'b0;
      feed_d <= 1'b0;
      pcnt   <= '0;
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      run_d  <= run_s;
      feed_d <= feed_s;
      expire <= 1'b0;
      if (start) begin
        live <= 1'b1;
        cnt  <= reload;
        pcnt <= '0;
      end else if (live) begin
        if (feed_hit) begin
          // feed outranks an expiry in the same cycle
          cnt  <= reload;
          pcnt <= '0;
        end else if (tick) begin
          pcnt <= '0;
          if (cnt == '0) begin
            expire <= 1'b1;
            cnt    <= reload;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iwdt_top.sv
`timescale 1ns/1ps
module iwdt_top #(
  parameter int RLD_W       = 12,
  parameter int WIDE_DIV    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_bus,
  input  logic        rst_bus,
  input  logic        clk_slow,
  input  logic        rst_slow,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic        pre_busy,
  output logic        rld_busy,
  output logic        wdg_active,
  output logic        osc_force_on,
  output logic        reset_req
);
  localparam int CODE_W   = (WIDE_DIV != 0) ? 4 : 3;
  localparam int MAX_CODE = (WIDE_DIV != 0) ? 8 : 6;
  localparam int DIVW     = MAX_CODE + 2;

  logic              pre_ld;
  logic              rld_ld;
  logic              feed_tgl;
  logic              run_s;
  logic              feed_s;
  logic              feed_hit;
  logic              zero_tick;
  logic [CODE_W-1:0] code_s;
  logic [RLD_W-1:0]  rld_s;

  iwdt_keys u_keys (
    .clk(clk_bus), .rst(rst_bus), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .pre_busy(pre_busy), .rld_busy(rld_busy), .pre_ld(pre_ld), .rld_ld(rld_ld),
    .active(wdg_active), .osc_on(osc_force_on), .feed_tgl(feed_tgl)
  );

  iwdt_xfer #(.W(CODE_W), .RST_VAL('0), .STAGES(SYNC_STAGES)) u_div_xfer (
    .clk_a(clk_bus), .rst_a(rst_bus), .load_a(pre_ld), .din_a(bus_wdata[CODE_W-1:0]),
    .busy_a(pre_busy), .clk_b(clk_slow), .rst_b(rst_slow), .dout_b(code_s)
  );

  iwdt_xfer #(.W(RLD_W), .RST_VAL({RLD_W{1'b1}}), .STAGES(SYNC_STAGES)) u_rld_xfer (
    .clk_a(clk_bus), .rst_a(rst_bus), .load_a(rld_ld), .din_a(bus_wdata[RLD_W-1:0]),
    .busy_a(rld_busy), .clk_b(clk_slow), .rst_b(rst_slow), .dout_b(rld_s)
  );

  iwdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk_slow), .rst(rst_slow), .d(wdg_active), .q(run_s)
  );

  iwdt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_feed_sync (
    .clk(clk_slow), .rst(rst_slow), .d(feed_tgl), .q(feed_s)
  );

  iwdt_count #(.RLD_W(RLD_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .DIVW(DIVW)) u_count (
    .clk(clk_slow), .rst(rst_slow), .run_s(run_s), .feed_s(feed_s), .code(code_s),
    .reload(rld_s), .feed_hit(feed_hit), .zero_tick(zero_tick), .expire(reset_req)
  );
endmodule

// File: rtl/iwdt_checker.sv
`timescale 1ns/1ps
module iwdt_checker (
  input logic clk_bus,
  input logic rst_bus,
  input logic clk_slow,
  input logic rst_slow,
  input logic wdg_active,
  input logic osc_force_on,
  input logic pre_ld,
  input logic rld_ld,
  input logic pre_busy,
  input logic rld_busy,
  input logic run_s,
  input logic feed_hit,
  input logic zero_tick,
  input logic reset_req
);
  assert_active_sticky_R3: assert property (@(posedge clk_bus) disable iff (rst_bus)
    wdg_active |=> wdg_active);

  assert_osc_sticky_R3: assert property (@(posedge clk_bus) disable iff (rst_bus)
    osc_force_on |=> osc_force_on);

  assert_div_busy_R6: assert property (@(posedge clk_bus) disable iff (rst_bus)
    pre_ld |=> pre_busy);

  assert_rld_busy_R6: assert property (@(posedge clk_bus) disable iff (rst_bus)
    rld_ld |=> rld_busy);

  assert_idle_quiet_R4: assert property (@(posedge clk_slow) disable iff (rst_slow)
    !run_s |-> !reset_req);

  assert_feed_wins_R8: assert property (@(posedge clk_slow) disable iff (rst_slow)
    (feed_hit && zero_tick) |=> !reset_req);

  assert_single_pulse_R9: assert property (@(posedge clk_slow) disable iff (rst_slow)
    reset_req |=> !reset_req);
endmodule

bind iwdt_top iwdt_checker u_chk (
  .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_slow(clk_slow), .rst_slow(rst_slow),
  .wdg_active(wdg_active), .osc_force_on(osc_force_on), .pre_ld(pre_ld), .rld_ld(rld_ld),
  .pre_busy(pre_busy), .rld_busy(rld_busy), .run_s(run_s), .feed_hit(feed_hit),
  .zero_tick(zero_tick), .reset_req(reset_req)
);

// File: tb/iwdt_top_test.sv
`timescale 1ns/1ps
module iwdt_top_test;
  logic        clk_bus = 1'b0;
  logic        clk_slow = 1'b0;
  logic        rst_bus = 1'b1;
  logic        rst_slow = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic        pre_busy, rld_busy, wdg_active, osc_force_on, reset_req;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  int slow_cyc = 0, pulses = 0, last_at = 0, last_gap = 0;
  int short_gaps = 0, wide_hits = 0, gap_limit = 0;
  logic prev_req = 1'b0;

  always #10 clk_bus = ~clk_bus;   // 50 MHz
  always #50 clk_slow = ~clk_slow; // slow domain

  iwdt_top uut (
    .clk_bus(clk_bus), .rst_bus(rst_bus), .clk_slow(clk_slow), .rst_slow(rst_slow),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pre_busy(pre_busy), .rld_busy(rld_busy), .wdg_active(wdg_active),
    .osc_force_on(osc_force_on), .reset_req(reset_req)
  );

  // slow-domain observer: pulse times, gaps and widths
  always @(negedge clk_slow) begin
    slow_cyc++;
    if (!rst_slow && reset_req) begin
      if (pulses > 0) begin
        last_gap = slow_cyc - last_at;
        if (gap_limit > 0 && last_gap < gap_limit) short_gaps++;
      end
      last_at = slow_cyc;
      pulses++;
      if (prev_req) wide_hits++;
    end
    prev_req = reset_req;
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_bus);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_bus);
    bus_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200 && (pre_busy || rld_busy); n++) @(negedge clk_bus);
  endtask

  task automatic wait_pulses(input int n);
    int tgt;
    tgt = pulses + n;
    while (pulses < tgt) @(negedge clk_bus);
  endtask

  task automatic t_reset_state();
    chk("R6 pre_busy after reset", pre_busy, 0);
    chk("R6 rld_busy after reset", rld_busy, 0);
    chk("R3 wdg_active after reset", wdg_active, 0);
    chk("R3 osc_force_on after reset", osc_force_on, 0);
    chk("R4 reset_req after reset", reset_req, 0);
  endtask

  task automatic t_locked_write();
    bus_wr(2'd1, 16'd2);
    chk("R5 locked divide write", pre_busy, 0);
    bus_wr(2'd2, 16'd3);
    chk("R5 locked reload write", rld_busy, 0);
  endtask

  task automatic t_update();
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd1, 16'd0);
    chk("R6 divide busy raised", pre_busy, 1);
    bus_wr(2'd2, 16'd9);
    chk("R6 reload busy raised", rld_busy, 1);
    bus_wr(2'd2, 16'd5);                  // ignored while busy, R6
    repeat (2) @(negedge clk_bus);
    chk("R6 reload busy held during handshake", rld_busy, 1);
    wait_idle();
    chk("R6 divide busy cleared", pre_busy, 0);
    chk("R6 reload busy cleared", rld_busy, 0);
  endtask

  task automatic t_relock();
    bus_wr(2'd0, 16'h1234);
    bus_wr(2'd1, 16'd5);
    chk("R5 write after relock by other key", pre_busy, 0);
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd0, 16'hAAAA);
    bus_wr(2'd2, 16'd1);
    chk("R5 write after relock by feed key", rld_busy, 0);
    repeat (100) @(negedge clk_slow);
    chk("R4 no request before start", pulses, 0);
  endtask

  task automatic t_start();
    bus_wr(2'd0, 16'hCCCC);
    chk("R3 active after start", wdg_active, 1);
    chk("R3 oscillator held after start", osc_force_on, 1);
    wait_pulses(3);
    chk("R2 period code0 reload9 (R5/R6 ignored writes)", last_gap, 40);
    chk("R9 single-cycle request", wide_hits, 0);
  endtask

  task automatic t_feed();
    int base;
    wait_pulses(1);
    base = pulses;
    for (int i = 0; i < 15; i++) begin
      repeat (60) @(negedge clk_bus);
      bus_wr(2'd0, 16'hAAAA);
    end
    chk("R7 feeds suppress requests", pulses - base, 0);
  endtask

  task automatic t_no_stop();
    bus_wr(2'd0, 16'h0000);
    bus_wr(2'd0, 16'hFFFF);
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd0, 16'h3333);
    chk("R3 still active after other keys", wdg_active, 1);
    chk("R3 oscillator still held", osc_force_on, 1);
    wait_pulses(2);
    chk("R3 requests continue", last_gap, 40);
  endtask

  task automatic t_reconfig();
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd1, 16'd2);
    bus_wr(2'd2, 16'd3);
    wait_idle();
    wait_pulses(3);
    chk("R1 R2 period code2 reload3", last_gap, 64);
  endtask

  task automatic t_saturate();
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd1, 16'd7);
    bus_wr(2'd2, 16'd0);
    wait_idle();
    wait_pulses(3);
    chk("R1 code above top acts as divide 256", last_gap, 256);
  endtask

  task automatic t_sweep();
    int s0, w0;
    bus_wr(2'd0, 16'h5555);
    bus_wr(2'd1, 16'd0);
    bus_wr(2'd2, 16'd9);
    wait_idle();
    wait_pulses(3);
    chk("R9 full period after request", last_gap, 40);
    s0 = short_gaps;
    w0 = wide_hits;
    gap_limit = 40;
    for (int d = 180; d <= 220; d++) begin
      wait_pulses(1);
      repeat (d) @(negedge clk_bus);
      bus_wr(2'd0, 16'hAAAA);
    end
    wait_pulses(1);
    chk("R8 no request sooner than a period", short_gaps - s0, 0);
    chk("R9 request width in sweep", wide_hits - w0, 0);
  endtask

  initial begin
    repeat (6) @(negedge clk_slow);
    @(negedge clk_bus);
    rst_bus = 1'b0;
    rst_slow = 1'b0;
    @(negedge clk_bus);
    t_reset_state();
    t_locked_write();
    t_update();
    t_relock();
    t_start();
    t_feed();
    t_no_stop();
    t_reconfig();
    t_saturate();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule